// File: doc/BRIEF.md
# Converter Serial Port with End-of-Data Strobes

This block is the digital serial side of a codec-style converter that is connected to a DSP serial port. Its timing comes from one shift clock. An active-high frame-sync input starts a 16-bit transfer that runs in both directions at once. The conversion result waiting in the ADC holding register is sent out most significant bit first on `dr`. At the same time, a 16-bit word from the host is collected from `dx`. Outgoing bits change on rising shift-clock edges, and incoming bits are sampled on falling edges.

Each direction has its own active-low end-of-data strobe. In word mode a strobe drops for one shift-clock period once the whole word has moved. In byte mode it drops once the first byte has moved and stays low until the second byte is done, which lets a byte-wide host tell the two halves apart. The two lowest bits of a received word give its kind. A control word updates a small register, and that register drives the input-pair select and two general-purpose pins directly. Any other word is a DAC sample and is presented on a parallel output with a one-cycle valid strobe.

Top module: `sport_top`

## Requirements
- R1: While `rst` is high and after its release, `dr` is 0, both strobes are 1, `dac_valid` is 0, and `aux_sel`, `gp_out0` and `gp_out1` are 0.
- R2: The rising edge that samples `fsync` high while idle is edge 0. From edge 0 to edge 15, `dr` carries holding-register bit 15-k after edge k. After edge 16, and whenever no frame is active, `dr` is 0.
- R3: The falling edge that follows edge k (k = 0..15) samples `dx` as bit 15-k of the received word. The full word is acted on at edge 16.
- R4: With `byte_mode` at 0, `eodr_n` and `eodx_n` are both low for exactly the one cycle after edge 16 and high at all other times.
- R5: With `byte_mode` at 1, both strobes are low from edge 8 up to edge 16, which is 8 cycles, and high at all other times.
- R6: A received word with bits [1:0] = 11 is a control word. After edge 16 it sets `aux_sel` to word bit 5 (1 = auxiliary inputs), `gp_out0` to bit 10 and `gp_out1` to bit 11. It raises no `dac_valid`, and these outputs change at no other time.
- R7: Any other received word appears on `dac_data` with `dac_valid` high for exactly the one cycle after edge 16.
- R8: Toggling `dx` with no frame active has no effect on any output.
- R9: A pulse on `adc_valid` loads `adc_data` into the holding register. The word sent in a frame is the one held at edge 0, and a load during a frame only affects later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Shift clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_mode | input | 1 | 0 = word-mode strobes, 1 = byte-mode strobes |
| fsync | input | 1 | Active-high frame start, sampled on rising edge |
| dx | input | 1 | Serial DAC/control data from the host |
| dr | output | 1 | Serial ADC data to the host |
| eodr_n | output | 1 | End-of-data strobe for the outgoing direction |
| eodx_n | output | 1 | End-of-data strobe for the incoming direction |
| adc_data | input | 16 | Parallel ADC sample |
| adc_valid | input | 1 | Load strobe for `adc_data` |
| dac_data | output | 16 | Last received DAC word |
| dac_valid | output | 1 | One-cycle valid for `dac_data` |
| aux_sel | output | 1 | Input-pair select (1 = auxiliary) |
| gp_out0 | output | 1 | General-purpose output from control bit 10 |
| gp_out1 | output | 1 | General-purpose output from control bit 11 |

## Verification
The hardest case to reach is a holding-register load that arrives while a frame is already shifting. That load must leave the word on the line untouched and appear only in the next frame. The bench pokes `adc_valid` halfway through selected frames and tracks the expected holding value itself. A sweep of frames cycles through all four tag values and both strobe modes, so control and data words alternate under each strobe shape. Control words are also sent with no frame active, to show that `dx` is ignored there.

// File: rtl/sport_pkg.sv
package sport_pkg;
    typedef struct packed {
        logic aux;
        logic gp1;
        logic gp0;
    } ctrl_t;

    localparam int DIR_COUNT = 2;
endpackage

// File: rtl/sport_seq.sv
module sport_seq #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = WORD_W / 2,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic clk,
    input  logic rst,
    input  logic fsync,
    output logic active,
    output logic start,
    output logic half,
    output logic finish
);
    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        half   = st_q.active && (st_q.cnt == CNT_W'(BYTE_W - 1));
        finish = st_q.active && (st_q.cnt == CNT_W'(WORD_W - 1));
        start  = fsync && (!st_q.active || finish);
        st_d   = st_q;
        if (start) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (finish) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        active = st_q.active;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R2
    frame_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.active) |-> $past(st_q.cnt) == CNT_W'(WORD_W - 1));
endmodule

// File: rtl/sport_tx.sv
module sport_tx #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] adc_data,
    input  logic              adc_valid,
    input  logic              start,
    input  logic              active,
    input  logic              finish,
    output logic              dr
);
    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic [WORD_W-1:0] sh;
    } tx_t;

    tx_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adc_valid) st_d.hold = adc_data;
        if (start)
            st_d.sh = st_q.hold;
        else if (active && !finish)
            st_d.sh = {st_q.sh[WORD_W-2:0], 1'b0};
        dr = active && st_q.sh[WORD_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R2
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> !dr);
endmodule

// File: rtl/sport_rx.sv
module sport_rx
    import sport_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int TAG_W   = 2,
    parameter int AUX_BIT = 5,
    parameter int GP0_BIT = 10,
    parameter int GP1_BIT = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              finish,
    input  logic              bit_in,
    output logic [WORD_W-1:0] dac_data,
    output logic              dac_valid,
    output ctrl_t             ctrl
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] dac;
        logic              vld;
        ctrl_t             ctrl;
    } rx_t;

    rx_t st_d, st_q;
    logic [WORD_W-1:0] word;
    logic              is_ctrl;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        word     = {st_q.sh[WORD_W-2:0], bit_in};
        is_ctrl  = &word[TAG_W-1:0];
        if (active) st_d.sh = word;
        if (finish) begin
            if (is_ctrl) begin
                st_d.ctrl.aux = word[AUX_BIT];
                st_d.ctrl.gp0 = word[GP0_BIT];
                st_d.ctrl.gp1 = word[GP1_BIT];
            end else begin
                st_d.dac = word;
                st_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dac_data  = st_q.dac;
    assign dac_valid = st_q.vld;
    assign ctrl      = st_q.ctrl;

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.vld |=> !st_q.vld);
    // R6
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !finish |=> $stable(st_q.ctrl));
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> !st_q.vld);
endmodule

// File: rtl/sport_strobe.sv
module sport_strobe (
    input  logic clk,
    input  logic rst,
    input  logic byte_mode,
    input  logic half,
    input  logic finish,
    output logic eod_n
);
    typedef struct packed {
        logic low;
    } stb_t;

    stb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (byte_mode) st_d.low = half || (st_q.low && !finish);
        else           st_d.low = finish;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign eod_n = !st_q.low;

    // R4
    word_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.low && !byte_mode) |=> (!st_q.low || byte_mode));
endmodule

// File: rtl/sport_top.sv
module sport_top
    import sport_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              byte_mode,
    input  logic              fsync,
    input  logic              dx,
    output logic              dr,
    output logic              eodr_n,
    output logic              eodx_n,
    input  logic [WORD_W-1:0] adc_data,
    input  logic              adc_valid,
    output logic [WORD_W-1:0] dac_data,
    output logic              dac_valid,
    output logic              aux_sel,
    output logic              gp_out0,
    output logic              gp_out1
);
    localparam int BYTE_W = WORD_W / 2;

    logic  active, start, half, finish;
    logic  dx_fall_q;
    ctrl_t ctrl;
    logic [DIR_COUNT-1:0] eod_n;

    always_ff @(negedge sclk) begin
        dx_fall_q <= dx;
    end

    sport_seq #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_seq (
        .clk(sclk), .rst(rst), .fsync(fsync),
        .active(active), .start(start), .half(half), .finish(finish)
    );

    sport_tx #(.WORD_W(WORD_W)) u_tx (
        .clk(sclk), .rst(rst), .adc_data(adc_data), .adc_valid(adc_valid),
        .start(start), .active(active), .finish(finish), .dr(dr)
    );

    sport_rx #(.WORD_W(WORD_W)) u_rx (
        .clk(sclk), .rst(rst), .active(active), .finish(finish),
        .bit_in(dx_fall_q), .dac_data(dac_data), .dac_valid(dac_valid),
        .ctrl(ctrl)
    );

    for (genvar g = 0; g < DIR_COUNT; g++) begin : g_stb
        sport_strobe u_stb (
            .clk(sclk), .rst(rst), .byte_mode(byte_mode),
            .half(half), .finish(finish), .eod_n(eod_n[g])
        );
    end

    assign eodr_n  = eod_n[0];
    assign eodx_n  = eod_n[1];
    assign aux_sel = ctrl.aux;
    assign gp_out0 = ctrl.gp0;
    assign gp_out1 = ctrl.gp1;

    // R7
    data_or_ctrl_chk: assert property (@(posedge sclk) disable iff (rst)
        dac_valid |-> $past(active));
endmodule

// File: tb/sport_top_test.sv
module sport_top_test;
    logic        sclk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_mode = 1'b0;
    logic        fsync = 1'b0;
    logic        dx = 1'b0;
    logic        dr, eodr_n, eodx_n, dac_valid, aux_sel, gp_out0, gp_out1;
    logic [15:0] adc_data = '0;
    logic        adc_valid = 1'b0;
    logic [15:0] dac_data;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [15:0] hold_exp = '0;
    logic [2:0]  ctrl_exp = '0;

    always #4 sclk = ~sclk;

    sport_top uut (
        .sclk(sclk), .rst(rst), .byte_mode(byte_mode), .fsync(fsync),
        .dx(dx), .dr(dr), .eodr_n(eodr_n), .eodx_n(eodx_n),
        .adc_data(adc_data), .adc_valid(adc_valid), .dac_data(dac_data),
        .dac_valid(dac_valid), .aux_sel(aux_sel), .gp_out0(gp_out0),
        .gp_out1(gp_out1)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge sclk);
        #1;
    endtask

    task automatic check_ctrl(input string req);
        check(req, {13'd0, gp_out1, gp_out0, aux_sel}, {13'd0, ctrl_exp});
    endtask

    task automatic run_frame(input logic [15:0] dxw, input logic bm,
                             input logic poke, input logic [15:0] pokev);
        logic [15:0] sent;
        logic        lo;
        sent = hold_exp;
        byte_mode = bm;
        fsync = 1'b1;
        tick();
        fsync = 1'b0;
        dx = dxw[15];
        #1;
        check("R2 first bit", {15'd0, dr}, {15'd0, sent[15]});
        check("R4/R5 strobes idle", {14'd0, eodr_n, eodx_n}, 16'd3);
        for (int k = 1; k <= 17; k++) begin
            tick();
            if (k <= 15) dx = dxw[15-k];
            if (poke && k == 5) begin
                adc_data = pokev; adc_valid = 1'b1; hold_exp = pokev;
            end else begin
                adc_valid = 1'b0;
            end
            if (k == 16 && dxw[1:0] == 2'b11)
                ctrl_exp = {dxw[11], dxw[10], dxw[5]};
            #1;
            check("R2/R9 serial bit", {15'd0, dr},
                  {15'd0, (k <= 15) ? sent[15-k] : 1'b0});
            lo = bm ? (k >= 8 && k <= 15) : (k == 16);
            check(bm ? "R5 byte strobes" : "R4 word strobes",
                  {14'd0, eodr_n, eodx_n}, lo ? 16'd0 : 16'd3);
            check_ctrl("R6 control outputs");
            if (k == 16) begin
                if (dxw[1:0] == 2'b11) begin
                    check("R6 no valid on control", {15'd0, dac_valid}, 16'd0);
                end else begin
                    check("R7 valid", {15'd0, dac_valid}, 16'd1);
                    check("R3/R7 word", dac_data, dxw);
                end
            end else begin
                check("R7 valid width", {15'd0, dac_valid}, 16'd0);
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(); tick(); #1;
        check("R1 reset dr", {15'd0, dr}, 16'd0);
        check("R1 reset strobes", {14'd0, eodr_n, eodx_n}, 16'd3);
        check("R1 reset valid", {15'd0, dac_valid}, 16'd0);
        check_ctrl("R1 reset ctrl");
        tick();
        rst = 1'b0;
        tick(); tick(); #1;
        check("R1 after release", {12'd0, dr, eodr_n, eodx_n, dac_valid}, 16'd6);

        adc_data = 16'hA55A; adc_valid = 1'b1; hold_exp = 16'hA55A;
        tick();
        adc_valid = 1'b0;

        for (int f = 0; f < 32; f++) begin
            logic [15:0] w;
            w = 16'(f * 40503 + 7919);
            w[1:0] = 2'(f);
            run_frame(w, f[2], (f == 10 || f == 21), 16'(f * 4099 + 3));
            if (f % 5 == 0) begin
                adc_data = 16'(f * 12345 + 77); adc_valid = 1'b1;
                hold_exp = adc_data;
                tick();
                adc_valid = 1'b0;
            end
            tick();
        end

        // R8: dx activity outside a frame
        for (int i = 0; i < 40; i++) begin
            dx = i[0] | i[2];
            tick(); #1;
            check("R8 no valid idle", {15'd0, dac_valid}, 16'd0);
            check("R8 line idle", {13'd0, dr, eodr_n, eodx_n}, 16'd3);
            check_ctrl("R8 ctrl unchanged");
        end

        run_frame(16'hFFFF, 1'b0, 1'b0, 16'h0);
        run_frame(16'h0003, 1'b1, 1'b0, 16'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule